// File: doc/BRIEF.md
# Selectable-latency SRAM read output stage

This block is the read side of a synchronous static RAM's data pins. On each rising clock edge it captures a two-bit command into a small state machine. It then presents the word supplied by the memory array to a shared data bus, with a drive-enable for the bus drivers. A static mode input picks the read latency. With the mode input low, array data flows straight to the bus in the cycle after the read is captured. With it high, the data first passes through a rising-edge output register and appears one cycle later. A board that leaves the mode input tied high gets the registered mode, which is the default.

The state machine has four states. IDLE means deselected. READ is an active read or read burst, and WRITE is an active write or write burst. SLEEP is low power. Its transitions are taken on the clock edge:
- Any state moves to READ on a read command, to WRITE on a write command and to IDLE on a deselect.
- A no-op command keeps IDLE, READ or WRITE where they are, so a burst continues at one beat per cycle.
- SLEEP leaves on the first edge with the sleep input low. A no-op or a deselect sends it to IDLE. A read or a write sends it to READ or WRITE.
- An edge with the sleep input high moves every state to SLEEP.

The drivers are released at once whenever the output enable is high, the sleep input is high, or a write is active. A deselect reaches the drivers through one register fewer than read data does.

Top module: `rs_read_out`

## Requirements
- R1: While reset is asserted, and after it with no command, `dq_oe` is 0 and `dq` is all zeros.
- R2: With `pipe_en` = 0, a read command (`cmd` = 2'b01) captured at edge k makes `dq` follow `arr_q` combinationally, with `dq_oe` = 1, between edges k and k+1.
- R3: With `pipe_en` = 1, the `arr_q` value present between edges k and k+1 after a read captured at edge k is driven on `dq` between edges k+1 and k+2, with `dq_oe` = 1.
- R4: A no-op command (`cmd` = 2'b00) after a read continues the burst. A new array word reaches `dq` every cycle, with the latency of R2 or R3.
- R5: A deselect (`cmd` = 2'b11) captured at edge k releases the drivers from edge k in flow mode. In registered mode the beat already held in the output register stays driven until edge k+1, and the drivers are released after it, with no extra driven cycle.
- R6: From the edge that captures a write (`cmd` = 2'b10), and for as long as WRITE lasts, `dq_oe` is 0 in both modes. This holds even when the output register holds a valid read beat.
- R7: `oe_n` = 1 forces `dq_oe` to 0 without waiting for a clock edge. It leaves the read pipeline undisturbed, so the burst resumes on the bus once `oe_n` returns low.
- R8: `sleep` = 1 forces `dq_oe` to 0 at once, and each edge with `sleep` high enters SLEEP. Commands captured while `sleep` is high are ignored, so a read issued during sleep drives nothing after wake-up.
- R9: Whenever `dq_oe` is 0, `dq` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_en | input | 1 | 1 = registered read path, 0 = flow-through |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |
| cmd | input | 2 | Command: 00 no-op, 01 read, 10 write, 11 deselect |
| arr_q | input | DW | Word read from the memory array |
| dq | output | DW | Data toward the bus drivers |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The bench aims at the cycle a deselect takes effect in registered mode. A design that treats deselect like a read would drive one extra cycle. A design that gates with the live state would cut off the final beat. It places a write directly behind a read, so the output register still holds valid data, which a design that checks only the pipeline would put on the bus during the write. It toggles the output enable inside a burst: a design that resets the pipeline on the enable would lose the beats after it. It issues a read during sleep: a design that keeps taking commands while asleep would drive stale data on wake-up.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10,
        CMD_DES = 2'b11
    } rs_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } rs_state_e;

endpackage

// File: rtl/rs_cmd_fsm.sv
module rs_cmd_fsm
    import rs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep,
    input  logic [1:0] cmd,
    output rs_state_e  state,
    output logic       rd_act,
    output logic       wr_act
);

    rs_cmd_e   cmd_e;
    rs_state_e state_nx;

    assign cmd_e = rs_cmd_e'(cmd);

    // next-state decision
    always_comb begin
        state_nx = state;
        if (sleep) begin
            state_nx = ST_SLEEP;
        end else begin
            unique case (cmd_e)
                CMD_RD:  state_nx = ST_READ;
                CMD_WR:  state_nx = ST_WRITE;
                CMD_DES: state_nx = ST_IDLE;
                CMD_NOP: state_nx = (state == ST_SLEEP) ? ST_IDLE : state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // state-decoded outputs
    always_comb begin
        rd_act = 1'b0;
        wr_act = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_READ:  rd_act = 1'b1;
            ST_WRITE: wr_act = 1'b1;
            ST_SLEEP: ;
        endcase
    end

    // R8
    sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (state == ST_SLEEP));

    // R5
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && cmd == 2'b11) |=> (state == ST_IDLE));

    // R6
    write_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && cmd == 2'b10) |=> wr_act);

endmodule

// File: rtl/rs_out_reg.sv
module rs_out_reg #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_act,
    input  logic          sleep,
    input  logic [DW-1:0] arr_q,
    output logic          pipe_vld,
    output logic [DW-1:0] pipe_dat
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_vld <= 1'b0;
            pipe_dat <= '0;
        end else begin
            pipe_vld <= rd_act & ~sleep;
            if (rd_act) pipe_dat <= arr_q;
        end
    end

    // R3
    pipe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !sleep) |=> (pipe_vld && pipe_dat == $past(arr_q)));

endmodule

// File: rtl/rs_drv_ctl.sv
module rs_drv_ctl #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_en,
    input  logic          oe_n,
    input  logic          sleep,
    input  logic          rd_act,
    input  logic          wr_act,
    input  logic          pipe_vld,
    input  logic [DW-1:0] pipe_dat,
    input  logic [DW-1:0] arr_q,
    output logic [DW-1:0] dq,
    output logic          dq_oe
);

    logic          src_vld;
    logic [DW-1:0] src_dat;

    always_comb begin
        src_vld = pipe_en ? pipe_vld : rd_act;
        src_dat = pipe_en ? pipe_dat : arr_q;
        dq_oe   = src_vld & ~wr_act & ~oe_n & ~sleep;
        dq      = dq_oe ? src_dat : '0;
    end

    // R6
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_act |-> !dq_oe);

    // R7
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    // R8
    sleep_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq == '0));

endmodule

// File: rtl/rs_read_out.sv
module rs_read_out
    import rs_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_en,
    input  logic          oe_n,
    input  logic          sleep,
    input  logic [1:0]    cmd,
    input  logic [DW-1:0] arr_q,
    output logic [DW-1:0] dq,
    output logic          dq_oe
);

    rs_state_e     state;
    logic          rd_act;
    logic          wr_act;
    logic          pipe_vld;
    logic [DW-1:0] pipe_dat;

    rs_cmd_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .cmd    (cmd),
        .state  (state),
        .rd_act (rd_act),
        .wr_act (wr_act)
    );

    rs_out_reg #(.DW(DW)) u_oreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_act   (rd_act),
        .sleep    (sleep),
        .arr_q    (arr_q),
        .pipe_vld (pipe_vld),
        .pipe_dat (pipe_dat)
    );

    rs_drv_ctl #(.DW(DW)) u_drv (
        .clk      (clk),
        .rst_n    (rst_n),
        .pipe_en  (pipe_en),
        .oe_n     (oe_n),
        .sleep    (sleep),
        .rd_act   (rd_act),
        .wr_act   (wr_act),
        .pipe_vld (pipe_vld),
        .pipe_dat (pipe_dat),
        .arr_q    (arr_q),
        .dq       (dq),
        .dq_oe    (dq_oe)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!dq_oe && state == ST_IDLE));

endmodule

// File: tb/rs_read_out_tb.sv
`timescale 1ns/1ps
module rs_read_out_tb;

    localparam int DW = 36;

    typedef struct {
        logic          oe;
        logic [DW-1:0] dat;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_en = 1'b1;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [1:0]    cmd = 2'b00;
    logic [DW-1:0] arr_q = '0;
    logic [DW-1:0] dq;
    logic          dq_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    exp_t sb[$];

    // reference state, written from the requirements
    int            m_st  = 0;   // 0 idle, 1 read, 2 write, 3 sleep
    logic          m_vld = 1'b0;
    logic [DW-1:0] m_dat = '0;

    always #10 clk = ~clk;

    rs_read_out #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pipe_en(pipe_en), .oe_n(oe_n),
        .sleep(sleep), .cmd(cmd), .arr_q(arr_q), .dq(dq), .dq_oe(dq_oe)
    );

    task automatic check(input logic oe_a, input logic [DW-1:0] d_a, input exp_t e);
        total++;
        if (oe_a !== e.oe || d_a !== e.dat) begin
            bad++;
            $display("FAIL %s: got oe=%b dq=%h, want oe=%b dq=%h",
                     e.req, oe_a, d_a, e.oe, e.dat);
        end
    endtask

    // driver: apply one cycle of stimulus, push the expectation, advance the model
    task automatic step(input logic [1:0] c, input logic [DW-1:0] a,
                        input logic p, input logic o, input logic s, input string req);
        exp_t e;
        logic src;
        @(negedge clk);
        cmd = c; arr_q = a; pipe_en = p; oe_n = o; sleep = s;
        src   = p ? m_vld : (m_st == 1);
        e.oe  = src && (m_st != 2) && !o && !s;
        e.dat = e.oe ? (p ? m_dat : a) : '0;
        e.req = req;
        sb.push_back(e);
        @(posedge clk);
        m_vld = (m_st == 1) && !s;
        if (m_st == 1) m_dat = a;
        if (s)                m_st = 3;
        else if (c == 2'b01)  m_st = 1;
        else if (c == 2'b10)  m_st = 2;
        else if (c == 2'b11)  m_st = 0;
        else if (m_st == 3)   m_st = 0;
    endtask

    // monitor: compare each pushed expectation shortly after the driving edge
    always @(negedge clk) begin
        #2;
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(dq_oe, dq, e);
        end
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got running, want finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exp_t e0;
        // R1: reset holds the bus released even with a read command present
        cmd = 2'b01; arr_q = 36'hABC;
        repeat (3) @(posedge clk);
        @(negedge clk);
        e0.oe = 1'b0; e0.dat = '0; e0.req = "R1 in reset";
        sb.push_back(e0);
        @(negedge clk);
        rst_n = 1'b1;
        cmd = 2'b00;
        step(2'b00, 36'h1, 1, 0, 0, "R1 after reset");

        // flow-through read burst then deselect
        step(2'b01, 36'h100, 0, 0, 0, "R2 read capture");
        step(2'b00, 36'h111, 0, 0, 0, "R2 flow first beat");
        step(2'b00, 36'h122, 0, 0, 0, "R4 flow burst");
        step(2'b11, 36'h133, 0, 0, 0, "R5 flow last beat");
        step(2'b00, 36'h144, 0, 0, 0, "R5 flow released");

        // registered read burst then deselect
        step(2'b01, 36'h200, 1, 0, 0, "R3 read capture");
        step(2'b00, 36'h211, 1, 0, 0, "R3 fill cycle");
        step(2'b00, 36'h222, 1, 0, 0, "R3 first beat");
        step(2'b00, 36'h233, 1, 0, 0, "R4 pipe burst");
        step(2'b11, 36'h244, 1, 0, 0, "R4 pipe burst at deselect");
        step(2'b00, 36'h255, 1, 0, 0, "R5 pipe last beat held");
        step(2'b00, 36'h266, 1, 0, 0, "R5 pipe released");
        step(2'b00, 36'h277, 1, 0, 0, "R9 idle zero");

        // write directly behind a read, registered mode
        step(2'b01, 36'h300, 1, 0, 0, "R6 read capture");
        step(2'b00, 36'h311, 1, 0, 0, "R6 fill");
        step(2'b10, 36'h322, 1, 0, 0, "R6 beat before write");
        step(2'b00, 36'h333, 1, 0, 0, "R6 write releases valid beat");
        step(2'b00, 36'h344, 1, 0, 0, "R6 write burst");
        // write behind a read, flow mode
        step(2'b01, 36'h350, 0, 0, 0, "R6 flow read capture");
        step(2'b10, 36'h355, 0, 0, 0, "R6 flow beat");
        step(2'b00, 36'h366, 0, 0, 0, "R6 flow write released");

        // output enable inside a registered burst
        step(2'b01, 36'h400, 1, 0, 0, "R7 read capture");
        step(2'b00, 36'h411, 1, 0, 0, "R7 fill");
        step(2'b00, 36'h422, 1, 0, 0, "R7 beat");
        step(2'b00, 36'h433, 1, 1, 0, "R7 oe high releases");
        step(2'b00, 36'h444, 1, 1, 0, "R7 oe still high");
        step(2'b00, 36'h455, 1, 0, 0, "R7 burst resumes");
        step(2'b11, 36'h466, 1, 0, 0, "R7 beat at deselect");
        step(2'b00, 36'h477, 1, 0, 0, "R5 tail");
        step(2'b00, 36'h488, 1, 0, 0, "R5 released");

        // sleep
        step(2'b01, 36'h500, 1, 0, 0, "R8 read capture");
        step(2'b00, 36'h511, 1, 0, 0, "R8 fill");
        step(2'b00, 36'h522, 1, 0, 1, "R8 sleep releases");
        step(2'b01, 36'h533, 1, 0, 1, "R8 read ignored in sleep");
        step(2'b00, 36'h544, 1, 0, 0, "R8 wake no drive");
        step(2'b00, 36'h555, 1, 0, 0, "R8 still idle");
        step(2'b01, 36'h566, 0, 0, 1, "R8 flow read ignored");
        step(2'b00, 36'h577, 0, 0, 0, "R8 flow wake no drive");
        step(2'b00, 36'h588, 0, 0, 0, "R9 flow idle zero");

        @(negedge clk);
        #5;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule